// File: doc/BRIEF.md
# Thread Migration Decision Controller

This per-core controller watches the instruction-cache access stream of the thread running on its core. It decides when that thread should move to another core, and to which one. A saturating miss counter marks the local cache as saturated with code once enough misses have been seen since the team started. Only then does the controller begin recording hit/miss outcomes into a fixed-length sliding history. A move is considered only while that history is completely filled and holds enough misses.

The tag lookup across remote caches is done outside this block. When it reports a finished lookup while a move is allowed, the controller chooses a destination in a fixed order of preference:

1. the remote core reported to hold every searched tag;
2. otherwise the lowest-numbered idle core;
3. otherwise no move at all.

A chosen move is issued as a one-cycle command with the destination index. The same cycle carries a flush strobe for the external missed-tag list, and the controller empties its own history. A team-completion pulse returns the counter and the history to their start state.

Top module: `mig_ctrl`

## Requirements
- R1: A miss counter of MISS_W bits increments on every cycle with `acc_valid` and `acc_miss` both high and saturates at its maximum. The cache counts as saturated while the counter value is strictly greater than `cfg_full_thr`, judged on the counter value before the current cycle's access.
- R2: An access (`acc_valid` high) is recorded into the history only while the cache counts as saturated. Each record is one bit: 1 for a miss, 0 for a hit.
- R3: The history holds the newest WIN_LEN records (default 100). When a record arrives with the history already holding WIN_LEN records, the oldest one is discarded.
- R4: No move is decided unless WIN_LEN records have been written since the last clear of the history.
- R5: A move is allowed only when the number of miss records in the history is at least `cfg_dens_thr`. A `cfg_dens_thr` of 0 removes this condition. The other conditions are R1 and R4, and all are judged on the state before the current cycle.
- R6: In a cycle with `match_valid` high while a move is allowed, the destination is chosen in this order: `match_core` when `match_hit` is high; else the lowest-indexed core whose `idle_mask` bit is 1; else no command is issued.
- R7: The core's own index SELF_ID is never a destination. A `match_core` equal to SELF_ID counts as no match, and the `idle_mask` bit at SELF_ID is ignored.
- R8: A decision made in cycle N shows up after that clock edge as `mig_valid` high for exactly one cycle with `mig_core` holding the destination. `mig_core` reads 0 whenever `mig_valid` is low.
- R9: A move clears the history and raises `tag_flush` in the same cycle as `mig_valid`. An access in the deciding cycle is not recorded, but a miss in that cycle still advances the miss counter.
- R10: `team_done` clears the miss counter and the history, suppresses any decision in its cycle, and raises `tag_flush` for one cycle after the edge.
- R11: While `rst_n` is low, `mig_valid`, `mig_core` and `tag_flush` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_full_thr | input | MISS_W | Miss count that must be exceeded before the cache counts as saturated (256 is the intended setting) |
| cfg_dens_thr | input | $clog2(WIN_LEN+1) | Minimum miss records in the history; 0 disables this condition (8 is the intended setting) |
| acc_valid | input | 1 | An instruction-cache access completes this cycle |
| acc_miss | input | 1 | That access missed |
| match_valid | input | 1 | The remote tag lookup has finished this cycle |
| match_hit | input | 1 | Some remote core holds all searched tags |
| match_core | input | $clog2(NUM_CORES) | Index of that core |
| idle_mask | input | NUM_CORES | One bit per core, 1 when that core is idle |
| team_done | input | 1 | The current team of threads has completed |
| mig_valid | output | 1 | One-cycle move command |
| mig_core | output | $clog2(NUM_CORES) | Destination core of the move |
| tag_flush | output | 1 | Clear strobe for the external missed-tag list |

## Verification
The bench sends a sparse miss pattern (one miss in ten accesses) against a low and then a high density threshold. This separates moves driven by miss density from the absence of any move, and shows that a move cannot come before the history has refilled. A self-index match with a mixed idle mask, a mask holding only the own core, and a no-match lookup with high idle cores separate the three destination choices and the exclusion of the own core. A team-completion pulse in the middle of a miss burst, with an irregular access-valid pattern and a toggling lookup strobe, shows that the counter restarts and that no record is taken while the cache is not yet saturated.

// File: rtl/mig_pkg.sv
package mig_pkg;

  // Where a destination came from
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MATCH = 2'd1,
    SRC_IDLE  = 2'd2
  } pick_src_e;

endpackage

// File: rtl/mig_miss_cnt.sv
module mig_miss_cnt #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [MISS_W-1:0] thr,
  output logic              sat_full
);

  logic [MISS_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != {MISS_W{1'b1}})) begin
      cnt_d = cnt_q + {{(MISS_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign sat_full = (cnt_q > thr);

endmodule

// File: rtl/mig_hist_win.sv
module mig_hist_win #(
  parameter int WIN_LEN = 100,
  localparam int PW     = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rec_en,
  input  logic          rec_bit,
  output logic [PW-1:0] pop,
  output logic [PW-1:0] fill,
  output logic          filled
);

  localparam logic [PW-1:0] LEN_V = PW'(WIN_LEN);
  localparam logic [PW-1:0] ONE_V = {{(PW-1){1'b0}}, 1'b1};

  logic [WIN_LEN-1:0] bits_q, bits_d;
  logic [PW-1:0]      pop_q, pop_d;
  logic [PW-1:0]      fill_q, fill_d;
  logic               win_en;
  logic               old_bit;

  assign old_bit = bits_q[WIN_LEN-1];
  assign win_en  = clr | rec_en;

  always_comb begin
    bits_d = bits_q;
    pop_d  = pop_q;
    fill_d = fill_q;
    if (clr) begin
      bits_d = '0;
      pop_d  = '0;
      fill_d = '0;
    end else if (rec_en) begin
      bits_d = {bits_q[WIN_LEN-2:0], rec_bit};
      // running miss total: add newcomer, drop the record leaving the far end
      pop_d  = pop_q + {{(PW-1){1'b0}}, rec_bit} - {{(PW-1){1'b0}}, old_bit};
      if (fill_q != LEN_V) begin
        fill_d = fill_q + ONE_V;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      pop_q  <= '0;
      fill_q <= '0;
    end else if (win_en) begin
      bits_q <= bits_d;
      pop_q  <= pop_d;
      fill_q <= fill_d;
    end
  end

  assign pop    = pop_q;
  assign fill   = fill_q;
  assign filled = (fill_q == LEN_V);

endmodule

// File: rtl/mig_tgt_pick.sv
module mig_tgt_pick
  import mig_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int SELF_ID   = 0,
  localparam int CW       = $clog2(NUM_CORES)
) (
  input  logic                 match_hit,
  input  logic [CW-1:0]        match_core,
  input  logic [NUM_CORES-1:0] idle_mask,
  output pick_src_e            src,
  output logic [CW-1:0]        tgt
);

  logic [NUM_CORES-1:0] idle_cand;
  logic                 idle_any;
  logic [CW-1:0]        idle_idx;
  logic                 match_ok;

  always_comb begin
    idle_cand          = idle_mask;
    idle_cand[SELF_ID] = 1'b0;
    idle_any           = 1'b0;
    idle_idx           = '0;
    // scan downwards so the lowest set index is the last one kept
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (idle_cand[i]) begin
        idle_any = 1'b1;
        idle_idx = CW'(i);
      end
    end
  end

  assign match_ok = match_hit
                  && (match_core != CW'(SELF_ID))
                  && (int'(match_core) < NUM_CORES);

  always_comb begin
    src = SRC_NONE;
    tgt = '0;
    if (match_ok) begin
      src = SRC_MATCH;
      tgt = match_core;
    end else if (idle_any) begin
      src = SRC_IDLE;
      tgt = idle_idx;
    end
  end

endmodule

// File: rtl/mig_ctrl.sv
module mig_ctrl
  import mig_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int SELF_ID   = 2,
  parameter int WIN_LEN   = 100,
  parameter int MISS_W    = 16,
  localparam int CW       = $clog2(NUM_CORES),
  localparam int PW       = $clog2(WIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MISS_W-1:0]    cfg_full_thr,
  input  logic [PW-1:0]        cfg_dens_thr,
  input  logic                 acc_valid,
  input  logic                 acc_miss,
  input  logic                 match_valid,
  input  logic                 match_hit,
  input  logic [CW-1:0]        match_core,
  input  logic [NUM_CORES-1:0] idle_mask,
  input  logic                 team_done,
  output logic                 mig_valid,
  output logic [CW-1:0]        mig_core,
  output logic                 tag_flush
);

  logic          sat_full;
  logic [PW-1:0] win_pop;
  logic [PW-1:0] win_fill;
  logic          win_filled;
  logic          dens_ok;
  logic          armed;
  logic          go;
  logic          win_clr;
  logic          rec_en;
  pick_src_e     pick_src;
  logic [CW-1:0] pick_tgt;

  logic          mv_q, mv_d;
  logic [CW-1:0] mc_q, mc_d;
  logic          fl_q, fl_d;

  mig_miss_cnt #(.MISS_W(MISS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (team_done),
    .inc      (acc_valid & acc_miss),
    .thr      (cfg_full_thr),
    .sat_full (sat_full)
  );

  mig_hist_win #(.WIN_LEN(WIN_LEN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (win_clr),
    .rec_en  (rec_en),
    .rec_bit (acc_miss),
    .pop     (win_pop),
    .fill    (win_fill),
    .filled  (win_filled)
  );

  mig_tgt_pick #(.NUM_CORES(NUM_CORES), .SELF_ID(SELF_ID)) u_pick (
    .match_hit  (match_hit),
    .match_core (match_core),
    .idle_mask  (idle_mask),
    .src        (pick_src),
    .tgt        (pick_tgt)
  );

  // two-stage gate: saturated cache, then miss density over a full history
  assign dens_ok = (cfg_dens_thr == '0) || (win_pop >= cfg_dens_thr);
  assign armed   = sat_full && win_filled && dens_ok;
  assign go      = !team_done && armed && match_valid && (pick_src != SRC_NONE);
  assign win_clr = team_done | go;
  assign rec_en  = sat_full && acc_valid && !win_clr;

  always_comb begin
    mv_d = go;
    mc_d = go ? pick_tgt : '0;
    fl_d = go | team_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q <= 1'b0;
      mc_q <= '0;
      fl_q <= 1'b0;
    end else begin
      mv_q <= mv_d;
      mc_q <= mc_d;
      fl_q <= fl_d;
    end
  end

  assign mig_valid = mv_q;
  assign mig_core  = mc_q;
  assign tag_flush = fl_q;

endmodule

// File: rtl/mig_ctrl_chk.sv
module mig_ctrl_chk #(
  parameter int NUM_CORES = 8,
  parameter int SELF_ID   = 2,
  parameter int WIN_LEN   = 100,
  localparam int CW       = $clog2(NUM_CORES),
  localparam int PW       = $clog2(WIN_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          team_done,
  input logic          match_valid,
  input logic          mig_valid,
  input logic [CW-1:0] mig_core,
  input logic          tag_flush,
  input logic [PW-1:0] win_pop,
  input logic [PW-1:0] win_fill
);

  // R8: a move empties the history, so a second command cannot follow at once
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |=> !mig_valid);

  // R7: the own core is never a destination
  a_r7_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> (mig_core != CW'(SELF_ID)));

  // R9: every move carries the tag-list flush
  a_r9_flush_with_move: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> tag_flush);

  // R10: team completion wins over any decision
  a_r10_team_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    team_done |=> (!mig_valid && tag_flush));

  // R6: a move needs a finished lookup in the deciding cycle
  a_r6_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |=> !mig_valid);

  // R3: the miss total can never exceed the number of records held
  a_r3_pop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pop <= win_fill) && (int'(win_fill) <= WIN_LEN));

  // R8: command index idles at zero
  a_r8_core_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mig_valid |-> (mig_core == '0));

endmodule

bind mig_ctrl mig_ctrl_chk #(
  .NUM_CORES (NUM_CORES),
  .SELF_ID   (SELF_ID),
  .WIN_LEN   (WIN_LEN)
) u_mig_ctrl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .team_done   (team_done),
  .match_valid (match_valid),
  .mig_valid   (mig_valid),
  .mig_core    (mig_core),
  .tag_flush   (tag_flush),
  .win_pop     (win_pop),
  .win_fill    (win_fill)
);

// File: tb/test_mig_ctrl.sv
module test_mig_ctrl;

  localparam int  NC      = 8;
  localparam int  SELF    = 2;
  localparam int  WIN     = 100;
  localparam int  MW      = 16;
  localparam int  CW      = $clog2(NC);
  localparam int  PW      = $clog2(WIN + 1);
  localparam time CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [MW-1:0] cfg_full_thr;
  logic [PW-1:0] cfg_dens_thr;
  logic          acc_valid, acc_miss, match_valid, match_hit, team_done;
  logic [CW-1:0] match_core;
  logic [NC-1:0] idle_mask;
  logic          mig_valid, tag_flush;
  logic [CW-1:0] mig_core;

  int    errors = 0;
  int    checks = 0;
  int    n_mig  = 0;
  string phase  = "R11";

  always #(CLK_PER / 2) clk = ~clk;

  mig_ctrl #(.NUM_CORES(NC), .SELF_ID(SELF), .WIN_LEN(WIN), .MISS_W(MW)) i_mig_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_full_thr(cfg_full_thr), .cfg_dens_thr(cfg_dens_thr),
    .acc_valid(acc_valid), .acc_miss(acc_miss), .match_valid(match_valid),
    .match_hit(match_hit), .match_core(match_core), .idle_mask(idle_mask),
    .team_done(team_done), .mig_valid(mig_valid), .mig_core(mig_core),
    .tag_flush(tag_flush)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt;
  bit m_hist[$];
  int m_fill;
  bit e_mv;
  int e_mc;
  bit e_fl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hist.delete(); m_fill = 0;
      e_mv = 0; e_mc = 0; e_fl = 0;
    end else begin
      bit full, armed, go;
      int pop, tgt;
      full = (m_cnt > int'(cfg_full_thr));                 // R1
      pop = 0;
      foreach (m_hist[k]) pop += m_hist[k];
      armed = full && (m_fill == WIN)                      // R4
              && (cfg_dens_thr == 0 || pop >= int'(cfg_dens_thr)); // R5
      go = 0; tgt = 0;
      if (!team_done && armed && match_valid) begin
        if (match_hit && int'(match_core) != SELF) begin   // R6, R7
          go = 1; tgt = match_core;
        end else begin
          for (int c = 0; c < NC; c++)
            if (!go && idle_mask[c] && c != SELF) begin go = 1; tgt = c; end
        end
      end
      e_mv = go; e_mc = go ? tgt : 0; e_fl = go || team_done; // R8, R9, R10
      if (team_done) begin
        m_cnt = 0; m_hist.delete(); m_fill = 0;
      end else begin
        if (acc_valid && acc_miss && m_cnt < (1 << MW) - 1) m_cnt++;
        if (go) begin
          m_hist.delete(); m_fill = 0;
        end else if (full && acc_valid) begin              // R2, R3
          m_hist.push_back(acc_miss);
          if (m_hist.size() > WIN) void'(m_hist.pop_front());
          if (m_fill < WIN) m_fill++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", phase, req, act, exp, $time);
    end
  endtask

  task automatic tick(input bit av, input bit am, input bit mv, input bit mh,
                      input int mc, input logic [NC-1:0] idle, input bit td);
    acc_valid = av; acc_miss = am; match_valid = mv; match_hit = mh;
    match_core = CW'(mc); idle_mask = idle; team_done = td;
    @(posedge clk);
    @(negedge clk);
    chk("R8 mig_valid", int'(mig_valid), int'(e_mv));
    chk("R6 mig_core", int'(mig_core), e_mc);
    chk("R9 tag_flush", int'(tag_flush), int'(e_fl));
    if (mig_valid) n_mig++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_full_thr = MW'(4); cfg_dens_thr = PW'(8);
    acc_valid = 0; acc_miss = 0; match_valid = 0; match_hit = 0;
    match_core = '0; idle_mask = '0; team_done = 0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    chk("R11 mig_valid", int'(mig_valid), 0);
    chk("R11 mig_core", int'(mig_core), 0);
    chk("R11 tag_flush", int'(tag_flush), 0);
    rst_n = 1'b1;

    // A: saturate counter, sparse misses, lookup points at core 5 (R1 R2 R3 R4 R5 R6)
    phase = "R1 R4 R6";
    n_mig = 0;
    for (int i = 0; i < 5; i++) tick(1, 1, 1, 1, 5, '0, 0);
    for (int i = 0; i < 320; i++) tick(1, (i % 10) == 0, 1, 1, 5, '0, 0);
    chk("R6 moves seen", int'(n_mig > 0), 1);

    // B: team restart, density above what sparse misses give (R10 R5)
    phase = "R10 R5";
    tick(1, 1, 1, 1, 5, '0, 1);
    cfg_dens_thr = PW'(20);
    n_mig = 0;
    for (int i = 0; i < 5; i++) tick(1, 1, 1, 1, 5, '0, 0);
    for (int i = 0; i < 300; i++) tick(1, (i % 10) == 0, 1, 1, 5, '0, 0);
    chk("R5 no move below density", n_mig, 0);
    for (int i = 0; i < 150; i++) tick(1, 1, 1, 1, 5, '0, 0);
    chk("R5 move once dense", int'(n_mig > 0), 1);

    // C: density off, match on own core, idle cores 1,2,5 -> core 1 (R7)
    phase = "R7 R5";
    cfg_dens_thr = '0;
    for (int i = 0; i < 250; i++)
      tick((i % 7) != 3, (i % 4) == 0, 1, 1, SELF, 8'b0010_0110, 0);
    n_mig = 0;
    for (int i = 0; i < 250; i++)
      tick((i % 7) != 3, (i % 4) == 0, 1, 1, SELF, 8'b0000_0100, 0);
    chk("R7 own-core-only idle gives no move", n_mig, 0);

    // D: no match, idle cores 6,7, toggling lookup strobe -> core 6 (R6)
    phase = "R6 R8";
    for (int i = 0; i < 300; i++)
      tick(1, (i % 3) == 0, (i % 2) == 0, 0, 1, 8'b1100_0000, 0);

    // E: team_done inside a miss burst, irregular valid (R10 R1 R2)
    phase = "R10 R2";
    cfg_dens_thr = PW'(8);
    for (int i = 0; i < 60; i++) tick((i % 5) != 1, 1, 1, 1, 3, '0, i == 30);
    for (int i = 0; i < 250; i++)
      tick((i % 5) != 1, (i % 6) == 0, (i % 3) != 2, 1, 3, 8'b0000_0001, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule